// File: doc/BRIEF.md
# Selectable Pulse Width Scaler

This block watches a single-bit pulse train whose duty cycle may change from pulse to pulse. For each pulse it rebuilds an output pulse whose high time is either twice or half the input high time. The input is first brought into the clock domain through a two-stage synchronizer. The block then measures the high time by counting clock cycles into an 8-bit up/down counter that can hold its value. After the input falls, it counts the stored value back down to zero, and that countdown sets how long the output stays high.

In doubling mode the output rises as soon as the input rise is detected and stays high through both the measurement and the countdown. In halving mode a toggle flip-flop lets the counter advance only on every other measurement clock. The output is then driven high only during the countdown. The resolution of the generated width is one clock period, so changing the clock frequency rescales all widths. A rise that arrives during a countdown abandons it and starts a new measurement. A count that reaches its maximum saturates and sets a sticky overflow flag.

Top module: `pulse_width_scaler`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `pulse_o` and `ovf_o` are 0 and the counter is zero.
- R2: Doubling mode is selected by `dbl_sel_i` = 1. Let W be the number of rising clock edges that sample `pulse_i` high. `pulse_o` goes high on the third edge after the first edge that samples `pulse_i` high, and it then stays high for exactly 2W cycles.
- R3: Halving mode is selected by `dbl_sel_i` = 0. `pulse_o` stays low during the measurement. It goes high on the third edge after the first edge that samples `pulse_i` low, and it stays high for floor(W/2) cycles. When W < 2 no output pulse is produced.
- R4: In halving mode the measurement counter advances on alternate clocks only, starting with the first clock after the rise is detected.
- R5: The countdown lowers the stored count by exactly one on every clock until it reaches zero, in both modes.
- R6: The counter saturates at 255 and does not wrap. In doubling mode, a pulse with W > 255 gives an output high time of W + 255 cycles.
- R7: `ovf_o` goes to 1 when a count at 255 is asked to increment. It then stays at 1 until reset.
- R8: A detected input rise during a countdown abandons that countdown, clears the counter and starts a new measurement. In doubling mode `pulse_o` stays high across the restart. In halving mode `pulse_o` goes low on that edge.
- R9: `dbl_sel_i` is captured on the edge that acts on the detected rise, which is the third edge counting the one that first samples `pulse_i` high. Changes to `dbl_sel_i` after that edge have no effect on the current pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Counting clock; sets the width resolution |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pulse_i | input | 1 | Asynchronous input pulse train |
| dbl_sel_i | input | 1 | 1 = double the high time, 0 = halve it |
| pulse_o | output | 1 | Rebuilt output pulse |
| ovf_o | output | 1 | Sticky flag: the counter hit its maximum |

## Verification
Every result trails the stimulus by a fixed number of edges. There are two synchronizer stages and one edge-detect register. A doubled pulse therefore appears on the third edge after the input is first sampled high. A halved pulse appears on the third edge after the input is first sampled low. The bench drives and samples on the falling clock edge and numbers each sample from the first high sample of the input. It records the sample index at which each output pulse starts and counts how many samples it stays high. It compares those numbers against start indices and widths worked out from the requirements, including two-pulse retrigger sequences whose second start falls inside the first countdown.

// File: rtl/pws_pkg.sv
package pws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MEAS  = 2'd1,
    ST_DRAIN = 2'd2
  } pws_state_e;
endpackage

// File: rtl/pws_sync_edge.sv
module pws_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/pws_rate_gate.sv
module pws_rate_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic preset_i,
  input  logic adv_i,
  input  logic half_i,
  output logic en_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tog_q <= 1'b0;
    else if (preset_i) tog_q <= 1'b1;
    else if (adv_i)    tog_q <= ~tog_q;
  end

  assign en_o = half_i ? (adv_i & tog_q) : adv_i;

  // R4
  tog_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !preset_i) |=> tog_q != $past(tog_q));

  // R4
  half_en_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_i && en_o && !preset_i) |=> !en_o);
endmodule

// File: rtl/pws_width_cnt.sv
module pws_width_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic [CNT_W-1:0] cnt_q, base, cnt_d;

  always_comb begin
    base  = clr_i ? '0 : cnt_q;
    sat_o = inc_i && (base == CntMax);
    if (inc_i && !sat_o)              cnt_d = base + 1'b1;
    else if (dec_i && (base != '0))   cnt_d = base - 1'b1;
    else                              cnt_d = base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R6
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && cnt_q == CntMax) |=> cnt_q == CntMax);

  // R5
  drain_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && !clr_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/pulse_width_scaler.sv
module pulse_width_scaler #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  input  logic dbl_sel_i,
  output logic pulse_o,
  output logic ovf_o
);
  import pws_pkg::*;

  localparam logic [CNT_W-1:0] CntOne = {{(CNT_W-1){1'b0}}, 1'b1};

  pws_state_e       st_q;
  logic             mode_q, pulse_q, ovf_q;
  logic             lvl, rise, fall;
  logic             gate_en, cnt_inc, cnt_dec, sat;
  logic [CNT_W-1:0] cnt;

  pws_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (pulse_i),
    .level_o (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  pws_rate_gate u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .preset_i (rise),
    .adv_i    ((st_q == ST_MEAS) && lvl),
    .half_i   (!mode_q),
    .en_o     (gate_en)
  );

  // doubling counts the rise cycle itself; halving starts from zero
  assign cnt_inc = rise ? dbl_sel_i : gate_en;
  assign cnt_dec = (st_q == ST_DRAIN) && !rise;

  pws_width_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rise),
    .inc_i  (cnt_inc),
    .dec_i  (cnt_dec),
    .cnt_o  (cnt),
    .sat_o  (sat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      mode_q  <= 1'b0;
      pulse_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      ovf_q <= ovf_q | sat;
      if (rise) begin
        st_q    <= ST_MEAS;
        mode_q  <= dbl_sel_i;
        pulse_q <= dbl_sel_i;
      end else begin
        case (st_q)
          ST_MEAS: if (fall) begin
            if (cnt == '0) begin
              st_q    <= ST_IDLE;
              pulse_q <= 1'b0;
            end else begin
              st_q    <= ST_DRAIN;
              pulse_q <= 1'b1;
            end
          end
          ST_DRAIN: if (cnt == CntOne) begin
            st_q    <= ST_IDLE;
            pulse_q <= 1'b0;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign pulse_o = pulse_q;
  assign ovf_o   = ovf_q;

  // R7
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  // R2
  dbl_meas_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_MEAS && mode_q) |-> pulse_o);

  // R3
  half_meas_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_MEAS && !mode_q) |-> !pulse_o);

  // R8
  retrigger_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> (st_q == ST_MEAS) && (cnt <= CntOne));

  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && !rise) |=> mode_q == $past(mode_q));

  // R5
  drain_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DRAIN) |-> (pulse_o && cnt != '0));
endmodule

// File: tb/pulse_width_scaler_bench.sv
module pulse_width_scaler_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_in = 1'b0;
  logic dbl_sel = 1'b1;
  logic pulse_out, ovf;
  int   n_chk = 0;
  int   n_fail = 0;

  always #2 clk = ~clk;

  pulse_width_scaler u_pulse_width_scaler (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .pulse_i   (pulse_in),
    .dbl_sel_i (dbl_sel),
    .pulse_o   (pulse_out),
    .ovf_o     (ovf)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // sample k counts falling edges after the first input-high drive
  task automatic measure(input bit sel, input int w1, input int gap, input int w2,
                         input int flip_k,
                         output int st1, output int wd1, output int st2, output int wd2);
    int  lim;
    bit  prev_p;
    lim = w1 + gap + w2 + 2 * (w1 + w2) + 40;
    st1 = -1; st2 = -1; wd1 = 0; wd2 = 0; prev_p = 1'b0;
    @(negedge clk);
    dbl_sel  = sel;
    pulse_in = (w1 > 0);
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk);
      if (pulse_out && !prev_p) begin
        if (st1 < 0) st1 = k;
        else if (st2 < 0) st2 = k;
      end
      if (pulse_out) begin
        if (st2 >= 0) wd2++;
        else wd1++;
      end
      prev_p = pulse_out;
      if (k == flip_k) dbl_sel = ~sel;
      pulse_in = (k < w1) || (k >= w1 + gap && k < w1 + gap + w2);
    end
  endtask

  task automatic t_reset();
    chk("R1", "pulse_o after reset", int'(pulse_out), 0);
    chk("R1", "ovf_o after reset", int'(ovf), 0);
  endtask

  task automatic t_double(input int w);
    int s1, d1, s2, d2;
    measure(1'b1, w, 0, 0, -1, s1, d1, s2, d2);
    chk("R2", $sformatf("double w=%0d start", w), s1, 3);
    chk("R2", $sformatf("double w=%0d width", w), d1, 2 * w);
  endtask

  task automatic t_half(input int w);
    int s1, d1, s2, d2;
    measure(1'b0, w, 0, 0, -1, s1, d1, s2, d2);
    chk("R3", $sformatf("half w=%0d width", w), d1, w / 2);
    if (w >= 2) chk("R4", $sformatf("half w=%0d start", w), s1, w + 3);
    else        chk("R3", "half w<2 no pulse", s1, -1);
  endtask

  task automatic t_sel_late();
    int s1, d1, s2, d2;
    measure(1'b1, 6, 0, 0, 3, s1, d1, s2, d2);
    chk("R9", "late switch to halve keeps doubling", d1, 12);
    measure(1'b0, 6, 0, 0, 3, s1, d1, s2, d2);
    chk("R9", "late switch to double keeps halving start", s1, 9);
    chk("R9", "late switch to double keeps halving width", d1, 3);
  endtask

  task automatic t_retrigger();
    int s1, d1, s2, d2;
    measure(1'b1, 10, 4, 5, -1, s1, d1, s2, d2);
    chk("R8", "double retrigger start", s1, 3);
    chk("R8", "double retrigger merged width", d1, 24);
    chk("R8", "double retrigger single pulse", s2, -1);
    measure(1'b0, 20, 2, 8, -1, s1, d1, s2, d2);
    chk("R8", "half retrigger cut width", d1, 2);
    chk("R8", "half retrigger second start", s2, 33);
    chk("R5", "half retrigger second width", d2, 4);
  endtask

  task automatic t_overflow();
    int s1, d1, s2, d2;
    chk("R7", "ovf_o before saturation", int'(ovf), 0);
    measure(1'b1, 300, 0, 0, -1, s1, d1, s2, d2);
    chk("R6", "saturated double width", d1, 300 + 255);
    chk("R7", "ovf_o after saturation", int'(ovf), 1);
    measure(1'b1, 4, 0, 0, -1, s1, d1, s2, d2);
    chk("R6", "normal width after saturation", d1, 8);
    chk("R7", "ovf_o still set", int'(ovf), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_double(5);
    t_double(12);
    t_double(1);
    t_half(8);
    t_half(7);
    t_half(2);
    t_half(1);
    t_half(20);
    t_sel_late();
    t_retrigger();
    t_overflow();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule